// File: doc/BRIEF.md
# Exclusive Access Monitor

This block is the local reservation tracker that pairs a load-exclusive with a later store-exclusive so that software can build locks and atomic read-modify-write sequences. A load-exclusive marks one word address as reserved. A store-exclusive is allowed to reach memory only while that same word is still reserved. The block reports in the same cycle whether the store went through.

The monitor holds one tag (a word address) and one valid flag. Any store-exclusive, whether it passes or fails, ends the reservation. A separate clear input, driven on exception entry or on a context switch, also drops the reservation so that an interrupted sequence cannot complete by accident. Memory reads, other requesters and coherence are handled elsewhere.

The pass/fail decision is combinational from the request and the current tag. The tag update takes effect at the next rising clock edge.

Top module: `excl_monitor`

## Requirements
- R1: After reset no address is reserved, so a store-exclusive issued before any load-exclusive fails.
- R2: A load-exclusive reserves the word that contains its address, and the reservation becomes visible from the next cycle on.
- R3: A load-exclusive issued while a reservation is held replaces it. A store-exclusive to the previously reserved word then fails.
- R4: `mem_we` is high only in a cycle with a store-exclusive whose word matches a held reservation. In that cycle `mem_addr` and `mem_wdata` carry the store's address and data.
- R5: Every store-exclusive pulses `sx_done` in its own cycle. On success `sx_status` is 0.
- R6: A successful store-exclusive ends the reservation, so a second store-exclusive to the same word fails and does not write.
- R7: A failed store-exclusive drives `sx_status` to 1 and keeps `mem_we` low.
- R8: Addresses are compared per word: the lowest GRAN_LSB address bits (two by default) are ignored.
- R9: A store-exclusive to a word other than the reserved one fails and also ends the reservation.
- R10: `excl_clr` ends the reservation, so the next store-exclusive fails.
- R11: Requests in the same cycle are handled as follows. A store is judged against the reservation held before that cycle. A load in the same cycle as a store leaves its word reserved afterwards. `excl_clr` overrides a load in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ldx_valid | input | 1 | Load-exclusive request |
| ldx_addr | input | ADDR_W | Load-exclusive byte address |
| stx_valid | input | 1 | Store-exclusive request |
| stx_addr | input | ADDR_W | Store-exclusive byte address |
| stx_data | input | DATA_W | Store-exclusive data |
| excl_clr | input | 1 | Drop any reservation |
| mem_we | output | 1 | Write enable toward memory |
| mem_addr | output | ADDR_W | Write address |
| mem_wdata | output | DATA_W | Write data |
| sx_done | output | 1 | Store-exclusive result valid |
| sx_status | output | 1 | 0 = stored, 1 = failed |

## Verification
The assertions check, on every cycle, that a write only happens alongside a store request, that a pass and a write always coincide, that a write or a clear is never followed by another write unless a load re-reserves first, and that results appear exactly when stores arrive. Only the bench scenarios can show the address-dependent behaviour: word-granular matching, a retag moving the reservation, a mismatched store ending the reservation, and the ordering of simultaneous requests. These depend on specific address sequences rather than on a one-cycle relation.

// File: rtl/excl_monitor_pkg.sv
package excl_monitor_pkg;
   typedef enum logic {
      SX_PASS = 1'b0,
      SX_FAIL = 1'b1
   } sx_result_e;

   // next-state action for the reservation register
   typedef enum logic [1:0] {
      RSV_HOLD = 2'd0,
      RSV_SET  = 2'd1,
      RSV_DROP = 2'd2
   } rsv_action_e;
endpackage

// File: rtl/excl_word_match.sv
module excl_word_match #(
   parameter int ADDR_W   = 32,
   parameter int GRAN_LSB = 2,
   localparam int TAG_W   = ADDR_W - GRAN_LSB
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [TAG_W-1:0]  tag,
   input  logic              tag_vld,
   output logic [TAG_W-1:0]  addr_tag,
   output logic              hit
);
   generate
      if (GRAN_LSB == 0) begin : g_byte
         assign addr_tag = addr;
      end else begin : g_word
         assign addr_tag = addr[ADDR_W-1:GRAN_LSB];
      end
   endgenerate

   assign hit = tag_vld && (addr_tag == tag);
endmodule

// File: rtl/excl_rsv_reg.sv
module excl_rsv_reg
   import excl_monitor_pkg::*;
#(
   parameter int TAG_W = 30
) (
   input  logic             clk,
   input  logic             rst_n,
   input  rsv_action_e      action,
   input  logic [TAG_W-1:0] new_tag,
   output logic [TAG_W-1:0] tag_q,
   output logic             vld_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         tag_q <= '0;
      end else begin
         unique case (action)
            RSV_SET: begin
               vld_q <= 1'b1;
               tag_q <= new_tag;
            end
            RSV_DROP: vld_q <= 1'b0;
            default:  ;
         endcase
      end
   end
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
   import excl_monitor_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int GRAN_LSB = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ldx_valid,
   input  logic [ADDR_W-1:0] ldx_addr,
   input  logic              stx_valid,
   input  logic [ADDR_W-1:0] stx_addr,
   input  logic [DATA_W-1:0] stx_data,
   input  logic              excl_clr,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              sx_done,
   output logic              sx_status
);
   localparam int TAG_W = ADDR_W - GRAN_LSB;

   generate
      if (GRAN_LSB < 0 || GRAN_LSB >= ADDR_W) begin : g_bad_gran
         $error("excl_monitor: GRAN_LSB must lie in [0, ADDR_W)");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("excl_monitor: DATA_W must be positive");
      end
   endgenerate

   logic [TAG_W-1:0] tag_q;
   logic             vld_q;
   logic [TAG_W-1:0] st_tag;
   logic [TAG_W-1:0] ld_tag;
   logic             st_hit;
   logic             ld_hit_unused;
   rsv_action_e      action;
   sx_result_e       result;

   excl_word_match #(.ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)) u_st_match (
      .addr     (stx_addr),
      .tag      (tag_q),
      .tag_vld  (vld_q),
      .addr_tag (st_tag),
      .hit      (st_hit)
   );

   excl_word_match #(.ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)) u_ld_tag (
      .addr     (ldx_addr),
      .tag      (tag_q),
      .tag_vld  (vld_q),
      .addr_tag (ld_tag),
      .hit      (ld_hit_unused)
   );

   // clear beats load; load beats the drop caused by a store
   always_comb begin
      if (excl_clr)
         action = RSV_DROP;
      else if (ldx_valid)
         action = RSV_SET;
      else if (stx_valid)
         action = RSV_DROP;
      else
         action = RSV_HOLD;
   end

   excl_rsv_reg #(.TAG_W(TAG_W)) u_rsv (
      .clk     (clk),
      .rst_n   (rst_n),
      .action  (action),
      .new_tag (ld_tag),
      .tag_q   (tag_q),
      .vld_q   (vld_q)
   );

   assign result    = (stx_valid && st_hit) ? SX_PASS : SX_FAIL;
   assign mem_we    = stx_valid && (result == SX_PASS);
   assign mem_addr  = stx_addr;
   assign mem_wdata = stx_data;
   assign sx_done   = stx_valid;
   assign sx_status = (result == SX_FAIL);
endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk (
   input logic clk,
   input logic rst_n,
   input logic ldx_valid,
   input logic stx_valid,
   input logic excl_clr,
   input logic mem_we,
   input logic sx_done,
   input logic sx_status
);
   // R4
   we_needs_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> stx_valid);

   // R5
   pass_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sx_done && !sx_status) |-> mem_we);

   // R7
   fail_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sx_done && sx_status) |-> !mem_we);

   // R5
   done_tracks_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sx_done == stx_valid);

   // R6
   no_double_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && !ldx_valid) |=> !mem_we);

   // R10
   clear_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      excl_clr |=> !mem_we);
endmodule

bind excl_monitor excl_monitor_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ldx_valid (ldx_valid),
   .stx_valid (stx_valid),
   .excl_clr  (excl_clr),
   .mem_we    (mem_we),
   .sx_done   (sx_done),
   .sx_status (sx_status)
);

// File: tb/sim_excl_monitor.sv
`timescale 1ns/1ps
module sim_excl_monitor;
   localparam int AW = 32;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ldx_valid = 1'b0;
   logic [AW-1:0] ldx_addr = '0;
   logic          stx_valid = 1'b0;
   logic [AW-1:0] stx_addr = '0;
   logic [DW-1:0] stx_data = '0;
   logic          excl_clr = 1'b0;
   logic          mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic          sx_done;
   logic          sx_status;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   excl_monitor u0 (
      .clk(clk), .rst_n(rst_n),
      .ldx_valid(ldx_valid), .ldx_addr(ldx_addr),
      .stx_valid(stx_valid), .stx_addr(stx_addr), .stx_data(stx_data),
      .excl_clr(excl_clr),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .sx_done(sx_done), .sx_status(sx_status)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle();
      @(negedge clk);
      ldx_valid = 0; stx_valid = 0; excl_clr = 0;
   endtask

   task automatic do_load(input logic [AW-1:0] a);
      @(negedge clk);
      ldx_valid = 1; ldx_addr = a; stx_valid = 0; excl_clr = 0;
      @(negedge clk);
      ldx_valid = 0;
   endtask

   task automatic do_clear();
      @(negedge clk);
      excl_clr = 1; ldx_valid = 0; stx_valid = 0;
      @(negedge clk);
      excl_clr = 0;
   endtask

   // drive a store for one cycle and check outputs in that cycle
   task automatic do_store(input string req, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, input bit exp_ok);
      @(negedge clk);
      stx_valid = 1; stx_addr = a; stx_data = d; ldx_valid = 0; excl_clr = 0;
      #2;
      check({req, " done"}, sx_done, 1);
      check({req, " status"}, sx_status, exp_ok ? 0 : 1);
      check({req, " we"}, mem_we, exp_ok);
      if (exp_ok) begin
         check({req, " addr"}, mem_addr, a);
         check({req, " data"}, mem_wdata, d);
      end
      @(negedge clk);
      stx_valid = 0;
   endtask

   task automatic t_reset();
      @(negedge clk); #2;
      check("R1 idle done", sx_done, 0);
      check("R1 idle we", mem_we, 0);
      do_store("R1 store after reset", 32'h100, 32'h11, 0);
   endtask

   task automatic t_basic();
      do_load(32'h200);
      do_store("R2/R4/R5 matched store", 32'h200, 32'hCAFE, 1);
      do_store("R6 second store", 32'h200, 32'hBEEF, 0);
   endtask

   task automatic t_retag();
      do_load(32'h300);
      do_load(32'h400);
      do_store("R3 old word after retag", 32'h300, 32'h1, 0);
      do_load(32'h300);
      do_load(32'h400);
      do_store("R3 new word after retag", 32'h400, 32'h2, 1);
   endtask

   task automatic t_gran();
      do_load(32'h501);
      do_store("R8 same word other byte", 32'h503, 32'h3, 1);
      do_load(32'h500);
      do_store("R8 next word", 32'h504, 32'h4, 0);
   endtask

   task automatic t_mismatch();
      do_load(32'h600);
      do_store("R9 mismatched store", 32'h700, 32'h5, 0);
      do_store("R9 reservation gone", 32'h600, 32'h6, 0);
      do_store("R7 fail status", 32'h600, 32'h7, 0);
   endtask

   task automatic t_clear();
      do_load(32'h800);
      do_clear();
      do_store("R10 store after clear", 32'h800, 32'h8, 0);
   endtask

   task automatic t_same_cycle();
      // load and store together: store uses old tag (none), load wins after
      idle();
      @(negedge clk);
      ldx_valid = 1; ldx_addr = 32'h900; stx_valid = 1; stx_addr = 32'h900; stx_data = 32'h9;
      #2;
      check("R11 store judged on old tag", sx_status, 1);
      @(negedge clk);
      ldx_valid = 0; stx_valid = 0;
      do_store("R11 load wins over store drop", 32'h900, 32'hA, 1);
      // clear and load together: clear wins
      @(negedge clk);
      ldx_valid = 1; ldx_addr = 32'hA00; excl_clr = 1;
      @(negedge clk);
      ldx_valid = 0; excl_clr = 0;
      do_store("R11 clear beats load", 32'hA00, 32'hB, 0);
      // held tag, store plus clear together: store still passes
      do_load(32'hB00);
      @(negedge clk);
      stx_valid = 1; stx_addr = 32'hB00; stx_data = 32'hC; excl_clr = 1;
      #2;
      check("R11 store with clear uses old tag", mem_we, 1);
      @(negedge clk);
      stx_valid = 0; excl_clr = 0;
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      if (!finished) begin
         n_run++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_basic();
      t_retag();
      t_gran();
      t_mismatch();
      t_clear();
      t_same_cycle();
      idle();
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule